// File: doc/BRIEF.md
# Deblocking Edge Strength Decision Unit

This unit decides how hard a video deblocking filter should smooth one edge between two 4x4 blocks. The edge is between the block before it (P) and the block after it (Q). For each edge it takes the slice-boundary flag and the macroblock-boundary flag. For each block it takes the prediction mode, the residual-coefficient flag, the reference picture index and both motion vector components. From these it produces a strength code from 0 (leave the edge alone) to 4 (strongest smoothing).

The conditions are tested in a fixed order of precedence, and the first one that matches sets the code. Slice boundaries switch filtering off. Intra coding gives the two top codes, chosen by whether the edge crosses a macroblock boundary. Residual coefficients come next. The last test compares references and motion. Motion vectors are in quarter-sample units, so a difference of one whole sample is 4 units. The two colour-difference planes reuse the code worked out for the matching brightness edge, so one instance serves all three planes.

The unit is pipelined with two register stages and takes one edge per clock cycle. A valid flag travels alongside the data.

Top module: `dbf_bstrength`

## Requirements
- R1: While reset is asserted and after it is released, with no edge yet accepted, `out_valid` is 0 and `out_bs` is 0.
- R2: An edge with `in_slice_edge` = 1 yields strength 0, whatever the other inputs are.
- R3: Off a slice boundary, if either block is intra coded and `in_mb_edge` = 1 (the blocks are in different macroblocks), the strength is 4.
- R4: Off a slice boundary, if either block is intra coded and `in_mb_edge` = 0 (both blocks are in the same macroblock), the strength is 3.
- R5: Off a slice boundary and with neither block intra coded, if either coded flag is 1, the strength is 2.
- R6: When R2 to R5 do not apply and the two reference indices differ, the strength is 1.
- R7: When R2 to R6 do not apply, the strength is 1 if the absolute difference of the horizontal or of the vertical motion components is at least `MV_THR` (default 4 quarter-sample units). Otherwise it is 0. Components are two's-complement, and the difference is taken at full precision with no wrap-around.
- R8: An edge presented with `in_valid` = 1 on clock edge k appears on `out_valid`/`out_bs` after clock edge k+2. A new edge may be accepted on every cycle, and `out_valid` follows `in_valid` with the same two-cycle delay.
- R9: With `IDLE_ZERO` = 1 (the default), `out_bs` is 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Edge descriptor present this cycle |
| in_slice_edge | input | 1 | Edge lies on a slice boundary |
| in_mb_edge | input | 1 | Edge lies on a macroblock boundary (1) or inside one (0) |
| in_p_intra | input | 1 | Block P is intra coded |
| in_q_intra | input | 1 | Block Q is intra coded |
| in_p_coded | input | 1 | Block P has non-zero residual coefficients |
| in_q_coded | input | 1 | Block Q has non-zero residual coefficients |
| in_p_ref | input | REF_W | Reference picture index of block P |
| in_q_ref | input | REF_W | Reference picture index of block Q |
| in_p_mvx | input | MV_W | Horizontal motion component of P, quarter samples |
| in_p_mvy | input | MV_W | Vertical motion component of P, quarter samples |
| in_q_mvx | input | MV_W | Horizontal motion component of Q, quarter samples |
| in_q_mvy | input | MV_W | Vertical motion component of Q, quarter samples |
| out_valid | output | 1 | Strength code present this cycle |
| out_bs | output | 3 | Strength code, 0 to 4 |

## Verification
The bench builds the unit with `MV_W` = 5 and `REF_W` = 2, keeping the default threshold of 4 and idle zeroing. At these widths it can sweep every pair of motion values for each component, from -16 against 15 down to equal values. That covers the full-precision difference at both extremes and both sides of the threshold. It also covers every combination of the six flag inputs against every pair of reference indices, once with small and once with large motion. Idle cycles are mixed into the stream to check the valid delay and the zeroed output.

// File: rtl/dbf_bs_pkg.sv
package dbf_bs_pkg;

   localparam int BS_W = 3;
   typedef logic [BS_W-1:0] bs_t;

   localparam bs_t BS_OFF      = 3'd0;
   localparam bs_t BS_MOTION   = 3'd1;
   localparam bs_t BS_RESIDUAL = 3'd2;
   localparam bs_t BS_INTRA_IN = 3'd3;
   localparam bs_t BS_INTRA_MB = 3'd4;

   // Reduced edge descriptor carried between the two stages
   typedef struct packed {
      logic slice;
      logic mb_edge;
      logic intra_any;
      logic coded_any;
      logic ref_diff;
      logic mv_big;
   } edge_flags_t;

endpackage

// File: rtl/dbf_bs_mvdiff.sv
module dbf_bs_mvdiff #(
   parameter int W   = 16,
   parameter int THR = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         big
);
   localparam int       DW    = W + 1;
   localparam logic [DW-1:0] THR_V = DW'(THR);

   generate
      if (W < 3) begin : g_bad_width
         $error("dbf_bs_mvdiff: W must be at least 3");
      end
      if (THR < 1 || THR >= (1 << W)) begin : g_bad_thr
         $error("dbf_bs_mvdiff: THR out of range");
      end
   endgenerate

   logic signed [DW-1:0] diff;
   logic        [DW-1:0] mag;

   always_comb begin
      diff = $signed({a[W-1], a}) - $signed({b[W-1], b});
      mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
      big  = (mag >= THR_V);
   end

   always_comb begin
      if (a == b) begin
         a_r7_equal_not_big: assert (!big);
      end
   end

endmodule

// File: rtl/dbf_bs_stage1.sv
module dbf_bs_stage1
   import dbf_bs_pkg::*;
#(
   parameter int MV_W   = 16,
   parameter int REF_W  = 4,
   parameter int MV_THR = 4,
   parameter int NCOMP  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  slice_edge,
   input  logic                  mb_edge,
   input  logic                  p_intra,
   input  logic                  q_intra,
   input  logic                  p_coded,
   input  logic                  q_coded,
   input  logic [REF_W-1:0]      p_ref,
   input  logic [REF_W-1:0]      q_ref,
   input  logic [NCOMP*MV_W-1:0] p_mv,
   input  logic [NCOMP*MV_W-1:0] q_mv,
   output logic                  s1_valid,
   output edge_flags_t           s1_flags
);

   generate
      if (REF_W < 1) begin : g_bad_ref
         $error("dbf_bs_stage1: REF_W must be positive");
      end
      if (NCOMP < 1) begin : g_bad_ncomp
         $error("dbf_bs_stage1: NCOMP must be positive");
      end
   endgenerate

   logic [NCOMP-1:0] comp_big;

   generate
      for (genvar c = 0; c < NCOMP; c++) begin : g_comp
         dbf_bs_mvdiff #(
            .W   (MV_W),
            .THR (MV_THR)
         ) mvdiff_i (
            .a   (p_mv[c*MV_W +: MV_W]),
            .b   (q_mv[c*MV_W +: MV_W]),
            .big (comp_big[c])
         );
      end
   endgenerate

   edge_flags_t flags_d;

   always_comb begin
      flags_d.slice     = slice_edge;
      flags_d.mb_edge   = mb_edge;
      flags_d.intra_any = p_intra | q_intra;
      flags_d.coded_any = p_coded | q_coded;
      flags_d.ref_diff  = (p_ref != q_ref);
      flags_d.mv_big    = |comp_big;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_flags <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_flags <= flags_d;
      end
   end

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);
   a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !s1_valid);

endmodule

// File: rtl/dbf_bs_decide.sv
module dbf_bs_decide
   import dbf_bs_pkg::*;
(
   input  edge_flags_t flags,
   output bs_t         bs
);

   always_comb begin
      if (flags.slice)
         bs = BS_OFF;
      else if (flags.intra_any)
         bs = flags.mb_edge ? BS_INTRA_MB : BS_INTRA_IN;
      else if (flags.coded_any)
         bs = BS_RESIDUAL;
      else if (flags.ref_diff || flags.mv_big)
         bs = BS_MOTION;
      else
         bs = BS_OFF;
   end

endmodule

// File: rtl/dbf_bstrength.sv
module dbf_bstrength
   import dbf_bs_pkg::*;
#(
   parameter int MV_W      = 16,
   parameter int REF_W     = 4,
   parameter int MV_THR    = 4,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_slice_edge,
   input  logic             in_mb_edge,
   input  logic             in_p_intra,
   input  logic             in_q_intra,
   input  logic             in_p_coded,
   input  logic             in_q_coded,
   input  logic [REF_W-1:0] in_p_ref,
   input  logic [REF_W-1:0] in_q_ref,
   input  logic [MV_W-1:0]  in_p_mvx,
   input  logic [MV_W-1:0]  in_p_mvy,
   input  logic [MV_W-1:0]  in_q_mvx,
   input  logic [MV_W-1:0]  in_q_mvy,
   output logic             out_valid,
   output logic [2:0]       out_bs
);
   localparam int NCOMP = 2;

   logic        s1_valid;
   edge_flags_t s1_flags;
   bs_t         bs_d;

   dbf_bs_stage1 #(
      .MV_W   (MV_W),
      .REF_W  (REF_W),
      .MV_THR (MV_THR),
      .NCOMP  (NCOMP)
   ) stage1_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .slice_edge (in_slice_edge),
      .mb_edge    (in_mb_edge),
      .p_intra    (in_p_intra),
      .q_intra    (in_q_intra),
      .p_coded    (in_p_coded),
      .q_coded    (in_q_coded),
      .p_ref      (in_p_ref),
      .q_ref      (in_q_ref),
      .p_mv       ({in_p_mvy, in_p_mvx}),
      .q_mv       ({in_q_mvy, in_q_mvx}),
      .s1_valid   (s1_valid),
      .s1_flags   (s1_flags)
   );

   dbf_bs_decide decide_i (
      .flags (s1_flags),
      .bs    (bs_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= s1_valid;
   end

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        out_bs <= BS_OFF;
            else if (s1_valid) out_bs <= bs_d;
            else               out_bs <= BS_OFF;
         end
         a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> out_bs == 3'd0);
      end else begin : g_idle_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        out_bs <= BS_OFF;
            else if (s1_valid) out_bs <= bs_d;
         end
      end
   endgenerate

   a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_bs <= 3'd4);
   a_r2_slice_off: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_slice_edge, 2) |-> out_bs == 3'd0);
   a_r3_intra_mb: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(!in_slice_edge && (in_p_intra || in_q_intra) && in_mb_edge, 2)
      |-> out_bs == 3'd4);
   a_r4_intra_inner: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(!in_slice_edge && (in_p_intra || in_q_intra) && !in_mb_edge, 2)
      |-> out_bs == 3'd3);
   a_r5_coded: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(!in_slice_edge && !in_p_intra && !in_q_intra
                         && (in_p_coded || in_q_coded), 2)
      |-> out_bs == 3'd2);
   a_r6_ref_diff: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(!in_slice_edge && !in_p_intra && !in_q_intra
                         && !in_p_coded && !in_q_coded && (in_p_ref != in_q_ref), 2)
      |-> out_bs == 3'd1);

endmodule

// File: tb/dbf_bstrength_tb.sv
`timescale 1ns/1ps
module dbf_bstrength_tb_top;
   localparam int MV_W  = 5;
   localparam int REF_W = 2;
   localparam int MVMIN = -(1 << (MV_W - 1));
   localparam int MVMAX = (1 << (MV_W - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_slice_edge = 1'b0, in_mb_edge = 1'b0;
   logic in_p_intra = 1'b0, in_q_intra = 1'b0;
   logic in_p_coded = 1'b0, in_q_coded = 1'b0;
   logic [REF_W-1:0] in_p_ref = '0, in_q_ref = '0;
   logic [MV_W-1:0]  in_p_mvx = '0, in_p_mvy = '0, in_q_mvx = '0, in_q_mvy = '0;
   logic             out_valid;
   logic [2:0]       out_bs;

   always #4 clk = ~clk;

   dbf_bstrength #(
      .MV_W  (MV_W),
      .REF_W (REF_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_slice_edge(in_slice_edge), .in_mb_edge(in_mb_edge),
      .in_p_intra(in_p_intra), .in_q_intra(in_q_intra),
      .in_p_coded(in_p_coded), .in_q_coded(in_q_coded),
      .in_p_ref(in_p_ref), .in_q_ref(in_q_ref),
      .in_p_mvx(in_p_mvx), .in_p_mvy(in_p_mvy),
      .in_q_mvx(in_q_mvx), .in_q_mvy(in_q_mvy),
      .out_valid(out_valid), .out_bs(out_bs)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected values of the two edges in flight
   int    pipe_v  [2];
   int    pipe_bs [2];
   string pipe_tag[2];

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic string tag_of(int s, int mb, int pi, int qi, int pc, int qc,
                                    int pr, int qr, int dx, int dy);
      if (s != 0)                         return "R2";
      if (pi != 0 || qi != 0)             return (mb != 0) ? "R3" : "R4";
      if (pc != 0 || qc != 0)             return "R5";
      if (pr != qr)                       return "R6";
      return "R7";
   endfunction

   function automatic int model_bs(int s, int mb, int pi, int qi, int pc, int qc,
                                   int pr, int qr, int dx, int dy);
      if (s != 0)                         return 0;
      if (pi != 0 || qi != 0)             return (mb != 0) ? 4 : 3;
      if (pc != 0 || qc != 0)             return 2;
      if (pr != qr)                       return 1;
      if (iabs(dx) >= 4 || iabs(dy) >= 4) return 1;
      return 0;
   endfunction

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: check the output due now, then present a new edge
   task automatic step(int v, int s, int mb, int pi, int qi, int pc, int qc,
                       int pr, int qr, int pmx, int pmy, int qmx, int qmy);
      @(negedge clk);
      check("R8", int'(out_valid), pipe_v[1], "out_valid");
      if (pipe_v[1] != 0) check(pipe_tag[1], int'(out_bs), pipe_bs[1], "out_bs");
      else                check("R9", int'(out_bs), 0, "idle out_bs");
      pipe_v[1]   = pipe_v[0];
      pipe_bs[1]  = pipe_bs[0];
      pipe_tag[1] = pipe_tag[0];
      pipe_v[0]   = v;
      pipe_bs[0]  = model_bs(s, mb, pi, qi, pc, qc, pr, qr, pmx - qmx, pmy - qmy);
      pipe_tag[0] = tag_of(s, mb, pi, qi, pc, qc, pr, qr, pmx - qmx, pmy - qmy);
      in_valid      = (v != 0);
      in_slice_edge = (s != 0);
      in_mb_edge    = (mb != 0);
      in_p_intra    = (pi != 0);
      in_q_intra    = (qi != 0);
      in_p_coded    = (pc != 0);
      in_q_coded    = (qc != 0);
      in_p_ref      = REF_W'(pr);
      in_q_ref      = REF_W'(qr);
      in_p_mvx      = MV_W'(pmx);
      in_p_mvy      = MV_W'(pmy);
      in_q_mvx      = MV_W'(qmx);
      in_q_mvy      = MV_W'(qmy);
   endtask

   task automatic idle();
      step(0, 1, 1, 1, 1, 1, 1, 1, 2, 0, 0, 0, 0);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         pipe_v[i] = 0; pipe_bs[i] = 0; pipe_tag[i] = "R1";
      end
      // R1: reset state, with valid input held high during reset
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", int'(out_valid), 0, "out_valid in reset");
      check("R1", int'(out_bs), 0, "out_bs in reset");
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(out_valid), 0, "out_valid after reset");
      check("R1", int'(out_bs), 0, "out_bs after reset");

      // flag and reference sweep, small then large motion (R2..R7)
      for (int big = 0; big < 2; big++) begin
         for (int f = 0; f < 64; f++) begin
            for (int pr = 0; pr < 4; pr++) begin
               for (int qr = 0; qr < 4; qr++) begin
                  step(1, f & 1, (f >> 1) & 1, (f >> 2) & 1, (f >> 3) & 1,
                       (f >> 4) & 1, (f >> 5) & 1, pr, qr,
                       big ? 8 : 3, -2, big ? -1 : 0, 1);
               end
            end
            if ((f % 8) == 7) idle();
         end
      end

      // full horizontal motion sweep, R7 threshold and extremes
      for (int a = MVMIN; a <= MVMAX; a++) begin
         for (int b = MVMIN; b <= MVMAX; b++) begin
            step(1, 0, (a & 1), 0, 0, 0, 0, 1, 1, a, 2, b, 2);
         end
         idle();
      end
      // full vertical motion sweep
      for (int a = MVMIN; a <= MVMAX; a++) begin
         for (int b = MVMIN; b <= MVMAX; b++) begin
            step(1, 0, 1, 0, 0, 0, 0, 3, 3, -5, a, -5, b);
         end
         if ((a & 3) == 0) begin idle(); idle(); end
      end
      // drain the pipeline
      repeat (3) idle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule